// File: doc/BRIEF.md
# Single-Transfer MMIO Bus Fabric

This block is a narrow memory-mapped I/O fabric. One requester reaches a set of register-file devices over it. The requester side takes a command made of an opcode, an address and write data. It places the command on a bus that every device sees, and holds it there until some device answers. It then drops the bus to IDLE and waits for the answer to fall back to READY. Only after that does it report completion and accept the next command, so at most one transfer exists anywhere on the bus.

Each device drives its own response code and read data. A return multiplexer picks the device whose response is not READY and forwards its response and data. The multiplexer does not decode the address. If no device answers within a programmable number of cycles, the requester ends the transfer with a FAULT completion.

The opcode has two parts. A 2-bit class selects control, load, store or swap. A 3-bit size selects a 32-bit word, a 64-bit word, or other encodings that these devices refuse. A swap returns the old contents and writes the new value in the same transfer.

Top module: `mmio_fabric`

## Requirements
- R1: After reset, `cmd_ready` is 1, `bus_opm` is 00000, `bus_ok` is 00 and `done` is 0.
- R2: A command whose opcode is 00000 (IDLE) is ignored. No bus transfer starts, `done` stays 0 and `cmd_ready` stays 1.
- R3: Response codes are READY=00, OK=01, HOLD=10 and FAULT=11. The opcode class sits in bits [4:3] (01 load, 10 store, 11 swap) and the size sits in bits [2:0] (010 is 32-bit, 011 is 64-bit). A 64-bit store completes with OK and read data 0. A later 64-bit load of the same address completes with OK and returns the stored value.
- R4: For a 32-bit access, address bit 2 selects the upper (1) or lower (0) half of a 64-bit register. A 32-bit load returns that half zero-extended. A 32-bit store changes only that half.
- R5: A swap returns the register's previous contents, or the previous selected half zero-extended for 32-bit. In the same transfer it writes the new value.
- R6: The request stays on the bus unchanged until a non-READY response arrives, and the bus then returns to IDLE. Completion (`done`) is reported only once the response is back at READY. For a device-answered transfer, `done` is high in the 4th cycle after the command is accepted. `cmd_ready` stays 0 from acceptance until `done`.
- R7: Device k (0-based) answers addresses whose bits [27:5] equal k. Address bits [4:3] pick one of its four 64-bit registers. The returned response and data come from the device that answered.
- R8: Class 00 with a non-zero size, or any size other than 010 or 011, completes with FAULT and read data 0. It leaves the addressed register unchanged.
- R9: With `timeout_limit` = L (L ≥ 1), a command that no device answers completes with FAULT and read data 0. `done` is high in cycle L+2 after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timeout_limit | input | 8 | Silent cycles allowed before a FAULT completion |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 5 | Command opcode: class [4:3], size [2:0] |
| cmd_addr | input | 28 | Command byte address |
| cmd_wdata | input | 64 | Command write data |
| cmd_ready | output | 1 | Requester idle, command accepted on this edge if valid |
| done | output | 1 | One-cycle completion pulse |
| done_resp | output | 2 | Completion response code |
| done_rdata | output | 64 | Completion read data |
| bus_opm | output | 5 | Opcode currently driven on the shared bus |
| bus_ok | output | 2 | Response currently returned by the mux |

## Verification
The bench sweeps every register of both devices with 64-bit and 32-bit stores, loads and swaps, and checks each against a shadow model. A wrong half select, or a store that is not merged into the other half, shows up as a mismatch in the untouched half. A device decoding the wrong address bits would corrupt its neighbour's registers. Completion latency is measured on every transfer. A requester that skipped the READY teardown would finish in fewer than four cycles, and one that issued twice would show `cmd_ready` high during a transfer. Refused opcodes and unmapped addresses under two timeout limits expose a device that writes on a refused opcode, a timeout counter that is off by one, and a fabric that hangs when nobody answers.

// File: rtl/mmio_pkg.sv
// Shared constants for the MMIO fabric: field widths, opcode parts and response codes.
package mmio_pkg;
    localparam int OP_W   = 5;
    localparam int ADDR_W = 28;
    localparam int DATA_W = 64;

    localparam logic [1:0] RSP_READY = 2'b00;
    localparam logic [1:0] RSP_OK    = 2'b01;
    localparam logic [1:0] RSP_HOLD  = 2'b10;
    localparam logic [1:0] RSP_FAULT = 2'b11;

    localparam logic [1:0] CLS_CTRL  = 2'b00;
    localparam logic [1:0] CLS_LOAD  = 2'b01;
    localparam logic [1:0] CLS_STORE = 2'b10;
    localparam logic [1:0] CLS_SWAP  = 2'b11;

    localparam logic [2:0] SZ_W32 = 3'b010;
    localparam logic [2:0] SZ_W64 = 3'b011;

    localparam logic [OP_W-1:0] OP_IDLE = '0;
endpackage

// File: rtl/mmio_requester.sv
// Requester-side sequencer. Holds one request on the bus until a final response
// (OK or FAULT) arrives, or until the timeout fires. It then drives IDLE and waits for
// READY before reporting completion.
// Assumes: timeout_limit >= 1; HOLD restarts the silence counter.
module mmio_requester
    import mmio_pkg::*;
#(
    parameter int TOW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOW-1:0]    timeout_limit,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              done,
    output logic [1:0]        done_resp,
    output logic [DATA_W-1:0] done_rdata,
    output logic [OP_W-1:0]   bus_opm,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_din,
    input  logic [1:0]        ret_ok,
    input  logic [DATA_W-1:0] ret_dout
);
    typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_TEAR} sq_t;

    sq_t               state;
    logic [OP_W-1:0]   op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        resp_q;
    logic [DATA_W-1:0] rdata_q;
    logic [TOW-1:0]    wait_cnt;

    // Sequence accept -> hold request -> teardown -> completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            op_q     <= OP_IDLE;
            addr_q   <= '0;
            wdata_q  <= '0;
            resp_q   <= RSP_READY;
            rdata_q  <= '0;
            wait_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (cmd_valid && cmd_op != OP_IDLE) begin
                        op_q     <= cmd_op;
                        addr_q   <= cmd_addr;
                        wdata_q  <= cmd_wdata;
                        wait_cnt <= '0;
                        state    <= SQ_REQ;
                    end
                end
                SQ_REQ: begin
                    if (ret_ok == RSP_OK || ret_ok == RSP_FAULT) begin
                        resp_q  <= ret_ok;
                        rdata_q <= ret_dout;
                        state   <= SQ_TEAR;
                    end else if (ret_ok == RSP_HOLD) begin
                        wait_cnt <= '0;
                    end else if (wait_cnt >= timeout_limit) begin
                        resp_q  <= RSP_FAULT;
                        rdata_q <= '0;
                        state   <= SQ_TEAR;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: begin
                    if (ret_ok == RSP_READY) begin
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end
                end
            endcase
        end
    end

    // Bus drive is a pure function of the sequencer state.
    always_comb begin
        cmd_ready  = (state == SQ_IDLE);
        bus_opm    = (state == SQ_REQ) ? op_q : OP_IDLE;
        bus_addr   = addr_q;
        bus_din    = wdata_q;
        done_resp  = resp_q;
        done_rdata = rdata_q;
    end

    assert_hold_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_opm != OP_IDLE && ret_ok == RSP_READY) |=>
            (bus_opm == OP_IDLE) || (bus_opm == $past(bus_opm) && bus_addr == $past(bus_addr)));

    assert_drop_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_opm != OP_IDLE && ret_ok == RSP_OK) |=> bus_opm == OP_IDLE);

    assert_done_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(ret_ok) == RSP_READY && bus_opm == OP_IDLE));
endmodule

// File: rtl/mmio_return_mux.sv
// Return path. Forwards the response and data of the device that is not at READY,
// with the lowest index winning. Assumes at most one device answers at a time.
module mmio_return_mux
    import mmio_pkg::*;
#(
    parameter int NUM_DEV = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_DEV*2-1:0]      dev_ok,
    input  logic [NUM_DEV*DATA_W-1:0] dev_dout,
    output logic [1:0]                ret_ok,
    output logic [DATA_W-1:0]         ret_dout
);
    logic [NUM_DEV-1:0] active;

    // Select the first non-READY responder.
    always_comb begin
        ret_ok   = RSP_READY;
        ret_dout = '0;
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            active[i] = (dev_ok[i*2 +: 2] != RSP_READY);
            if (active[i]) begin
                ret_ok   = dev_ok[i*2 +: 2];
                ret_dout = dev_dout[i*DATA_W +: DATA_W];
            end
        end
    end

    assert_one_responder_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active));
endmodule

// File: rtl/mmio_regfile_dev.sv
// Sample device: REGS 64-bit registers in the window where addr[ADDR_W-1:3+log2(REGS)] == IDX.
// It executes once per request, answers OK or FAULT, and holds that answer until
// the bus returns to IDLE. Refused opcodes never write.
module mmio_regfile_dev
    import mmio_pkg::*;
#(
    parameter int IDX  = 0,
    parameter int REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   bus_opm,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [1:0]        dev_ok,
    output logic [DATA_W-1:0] dev_dout
);
    localparam int IW      = $clog2(REGS);
    localparam int WIN_LSB = 3 + IW;
    localparam int TAG_W   = ADDR_W - WIN_LSB;

    logic [DATA_W-1:0] regs_q [REGS];
    logic              busy_q;
    logic [1:0]        ok_q;
    logic [DATA_W-1:0] dout_q;

    logic              hit, legal, writes, reads, hi_half;
    logic [1:0]        cls;
    logic [2:0]        sz;
    logic [IW-1:0]     sel;
    logic [DATA_W-1:0] old_val, rd_val, new_val;
    logic              unused_addr_bits;

    // Decode the broadcast request and form read and merged write values.
    always_comb begin
        cls     = bus_opm[4:3];
        sz      = bus_opm[2:0];
        sel     = bus_addr[3 +: IW];
        hi_half = bus_addr[2];
        hit     = (bus_opm != OP_IDLE) && (bus_addr[ADDR_W-1:WIN_LSB] == TAG_W'(IDX));
        legal   = (cls != CLS_CTRL) && (sz == SZ_W32 || sz == SZ_W64);
        writes  = (cls == CLS_STORE) || (cls == CLS_SWAP);
        reads   = (cls == CLS_LOAD) || (cls == CLS_SWAP);
        old_val = regs_q[sel];
        if (sz == SZ_W64) begin
            rd_val  = old_val;
            new_val = bus_din;
        end else begin
            rd_val  = {32'b0, hi_half ? old_val[63:32] : old_val[31:0]};
            new_val = hi_half ? {bus_din[31:0], old_val[31:0]} : {old_val[63:32], bus_din[31:0]};
        end
    end

    assign unused_addr_bits = ^bus_addr[1:0];

    // Execute on first sight of a hit, then hold the answer until teardown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ok_q   <= RSP_READY;
            dout_q <= '0;
            for (int r = 0; r < REGS; r++) regs_q[r] <= '0;
        end else if (!busy_q) begin
            if (hit) begin
                busy_q <= 1'b1;
                if (!legal) begin
                    ok_q   <= RSP_FAULT;
                    dout_q <= '0;
                end else begin
                    ok_q   <= RSP_OK;
                    dout_q <= reads ? rd_val : '0;
                    if (writes) regs_q[sel] <= new_val;
                end
            end
        end else if (bus_opm == OP_IDLE) begin
            busy_q <= 1'b0;
            ok_q   <= RSP_READY;
            dout_q <= '0;
        end
    end

    assign dev_ok   = ok_q;
    assign dev_dout = dout_q;

    assert_answer_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q != RSP_READY && bus_opm != OP_IDLE) |=> ok_q == $past(ok_q));

    assert_fault_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q == RSP_FAULT) |-> dout_q == '0);
endmodule

// File: rtl/mmio_fabric.sv
// Top level. One requester sequencer, NUM_DEV register-file devices on a broadcast
// bus, and the READY-based return multiplexer.
module mmio_fabric
    import mmio_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter int REGS    = 4,
    parameter int TOW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOW-1:0]    timeout_limit,
    input  logic              cmd_valid,
    input  logic [4:0]        cmd_op,
    input  logic [27:0]       cmd_addr,
    input  logic [63:0]       cmd_wdata,
    output logic              cmd_ready,
    output logic              done,
    output logic [1:0]        done_resp,
    output logic [63:0]       done_rdata,
    output logic [4:0]        bus_opm,
    output logic [1:0]        bus_ok
);
    logic [ADDR_W-1:0]         b_addr;
    logic [DATA_W-1:0]         b_din;
    logic [DATA_W-1:0]         r_dout;
    logic [NUM_DEV*2-1:0]      dev_ok_v;
    logic [NUM_DEV*DATA_W-1:0] dev_dout_v;

    mmio_requester #(.TOW(TOW)) u_req (
        .clk(clk), .rst_n(rst_n), .timeout_limit(timeout_limit),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ready(cmd_ready), .done(done), .done_resp(done_resp), .done_rdata(done_rdata),
        .bus_opm(bus_opm), .bus_addr(b_addr), .bus_din(b_din),
        .ret_ok(bus_ok), .ret_dout(r_dout)
    );

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        mmio_regfile_dev #(.IDX(g), .REGS(REGS)) u_dev (
            .clk(clk), .rst_n(rst_n),
            .bus_opm(bus_opm), .bus_addr(b_addr), .bus_din(b_din),
            .dev_ok(dev_ok_v[g*2 +: 2]), .dev_dout(dev_dout_v[g*DATA_W +: DATA_W])
        );
    end

    mmio_return_mux #(.NUM_DEV(NUM_DEV)) u_mux (
        .clk(clk), .rst_n(rst_n),
        .dev_ok(dev_ok_v), .dev_dout(dev_dout_v),
        .ret_ok(bus_ok), .ret_dout(r_dout)
    );
endmodule

// File: tb/sim_mmio_fabric.sv
`timescale 1ns/1ps
module sim_mmio_fabric;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  timeout_limit = 8'd8;
    logic        cmd_valid = 1'b0;
    logic [4:0]  cmd_op = '0;
    logic [27:0] cmd_addr = '0;
    logic [63:0] cmd_wdata = '0;
    logic        cmd_ready, done;
    logic [1:0]  done_resp, bus_ok;
    logic [63:0] done_rdata;
    logic [4:0]  bus_opm;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [63:0] model [2][4];

    localparam logic [4:0] LD64 = 5'b01_011, ST64 = 5'b10_011, SW64 = 5'b11_011;
    localparam logic [4:0] LD32 = 5'b01_010, ST32 = 5'b10_010, SW32 = 5'b11_010;

    mmio_fabric u0 (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL R6 watchdog expired: actual=%0d expected<=100000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int d, input int r, input int k);
        return 64'hA5C3_0000_0000_0000 ^ (64'(d) << 44) ^ (64'(r) << 24) ^ 64'(k * 7919 + 13);
    endfunction

    function automatic logic [27:0] adr(input int d, input int r, input bit hi);
        return 28'((d << 5) | (r << 3) | (hi ? 4 : 0));
    endfunction

    // One full transfer. Returns response, data, cycles to done and whether the requester stayed busy.
    task automatic xfer(input logic [4:0] op, input logic [27:0] a, input logic [63:0] wd,
                        output logic [1:0] rs, output logic [63:0] rd, output int lat);
        bit busy_ok;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        lat = 0; busy_ok = 1'b1;
        while (!done && lat < 300) begin
            @(posedge clk); #1;
            lat++;
            if (!done && cmd_ready) busy_ok = 1'b0;
        end
        rs = done_resp; rd = done_rdata;
        chk(busy_ok, "R6 single transfer (cmd_ready low while busy)", 64'(busy_ok), 64'd1);
        chk(bus_opm == 5'd0 && bus_ok == 2'd0, "R6 bus torn down at done", {bus_opm, bus_ok}, 64'd0);
    endtask

    task automatic run(input logic [4:0] op, input logic [27:0] a, input logic [63:0] wd,
                       input logic [1:0] exp_rs, input logic [63:0] exp_rd, input int exp_lat,
                       input string req);
        logic [1:0] rs; logic [63:0] rd; int lat;
        xfer(op, a, wd, rs, rd, lat);
        chk(rs == exp_rs, {req, " response"}, 64'(rs), 64'(exp_rs));
        chk(rd == exp_rd, {req, " read data"}, rd, exp_rd);
        chk(lat == exp_lat, {req, " latency"}, 64'(lat), 64'(exp_lat));
    endtask

    initial begin
        bit saw_done;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(cmd_ready && bus_opm == 0 && bus_ok == 0 && !done, "R1 reset state",
            {cmd_ready, bus_opm, bus_ok, done}, 64'h100);
        rst_n = 1'b1;
        for (int d = 0; d < 2; d++) for (int r = 0; r < 4; r++) model[d][r] = '0;

        // R2 IDLE opcode ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 5'd0; cmd_addr = adr(0, 1, 0); cmd_wdata = 64'hFFFF;
        saw_done = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            if (done || bus_opm != 0 || !cmd_ready) saw_done = 1'b1;
        end
        cmd_valid = 1'b0;
        chk(!saw_done, "R2 idle opcode starts nothing", 64'(saw_done), 64'd0);
        run(LD64, adr(0, 1, 0), 0, 2'b01, 64'd0, 4, "R2 register untouched after idle op");

        // R3 R7 store every register of both devices, then read all back
        for (int d = 0; d < 2; d++) for (int r = 0; r < 4; r++) begin
            model[d][r] = pat(d, r, 1);
            run(ST64, adr(d, r, 0), model[d][r], 2'b01, 64'd0, 4, "R3 64-bit store");
        end
        for (int d = 0; d < 2; d++) for (int r = 0; r < 4; r++)
            run(LD64, adr(d, r, 0), 0, 2'b01, model[d][r], 4, "R7 64-bit load from device window");

        // R4 32-bit halves
        for (int d = 0; d < 2; d++) for (int r = 0; r < 4; r++) for (int h = 0; h < 2; h++) begin
            logic [31:0] w;
            w = 32'(pat(d, r, 2 + h));
            run(ST32, adr(d, r, h[0]), {32'hDEAD_BEEF, w}, 2'b01, 64'd0, 4, "R4 32-bit store");
            if (h == 1) model[d][r][63:32] = w; else model[d][r][31:0] = w;
            run(LD64, adr(d, r, 0), 0, 2'b01, model[d][r], 4, "R4 half merge");
            run(LD32, adr(d, r, 1), 0, 2'b01, {32'b0, model[d][r][63:32]}, 4, "R4 upper half load");
            run(LD32, adr(d, r, 0), 0, 2'b01, {32'b0, model[d][r][31:0]}, 4, "R4 lower half load");
        end

        // R5 swaps
        for (int d = 0; d < 2; d++) for (int r = 0; r < 4; r++) begin
            logic [63:0] nv;
            nv = pat(d, r, 9);
            run(SW64, adr(d, r, 0), nv, 2'b01, model[d][r], 4, "R5 64-bit swap old value");
            model[d][r] = nv;
            run(LD64, adr(d, r, 0), 0, 2'b01, model[d][r], 4, "R5 64-bit swap new value");
        end
        run(SW32, adr(1, 2, 1), 64'h1111_2222_3333_4444, 2'b01, {32'b0, model[1][2][63:32]}, 4,
            "R5 32-bit swap old half");
        model[1][2][63:32] = 32'h3333_4444;
        run(LD64, adr(1, 2, 0), 0, 2'b01, model[1][2], 4, "R5 32-bit swap new half");

        // R8 refused opcodes: FAULT, no write
        run(5'b00_001, adr(0, 3, 0), 64'h55, 2'b11, 64'd0, 4, "R8 special command");
        run(5'b10_111, adr(0, 3, 0), 64'h66, 2'b11, 64'd0, 4, "R8 tile store");
        run(5'b10_000, adr(1, 0, 0), 64'h77, 2'b11, 64'd0, 4, "R8 size 000 store");
        run(5'b11_001, adr(1, 1, 0), 64'h88, 2'b11, 64'd0, 4, "R8 size 001 swap");
        run(5'b01_111, adr(1, 1, 0), 0, 2'b11, 64'd0, 4, "R8 tile load");
        run(LD64, adr(0, 3, 0), 0, 2'b01, model[0][3], 4, "R8 register unchanged dev0");
        run(LD64, adr(1, 0, 0), 0, 2'b01, model[1][0], 4, "R8 register unchanged dev1 r0");
        run(LD64, adr(1, 1, 0), 0, 2'b01, model[1][1], 4, "R8 register unchanged dev1 r1");

        // R9 timeout on unmapped addresses
        run(LD64, 28'h40, 0, 2'b11, 64'd0, 10, "R9 timeout limit 8");
        timeout_limit = 8'd3;
        run(ST64, 28'hFFF_FFE0, 64'h99, 2'b11, 64'd0, 5, "R9 timeout limit 3");
        timeout_limit = 8'd1;
        run(LD64, adr(1, 3, 0), 0, 2'b01, model[1][3], 4, "R9 device answers within limit 1");
        timeout_limit = 8'd8;
        for (int d = 0; d < 2; d++) for (int r = 0; r < 4; r++)
            run(LD64, adr(d, r, 0), 0, 2'b01, model[d][r], 4, "R7 final sweep after timeouts");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule